// File: doc/BRIEF.md
# Branch and Jump Decision Unit

This combinational unit tells the fetch stage whether the program counter must be redirected to a computed target. The decoder supplies a 3-bit branch kind, and the register file supplies two 32-bit operands. The unit compares the operands, picks the comparison result that the kind calls for, and drives a single taken flag. The kind encoding has an explicit code for "not a branch", which is never taken, and an explicit code for "unconditional jump", which is always taken. Six conditional comparisons fill the remaining codes.

Computing the target address, updating the PC and predicting branches are handled by neighbouring logic. There is no state: the flag follows the inputs within the same cycle.

Top module: `branch_decide`

## Requirements
- R1: The kind input is 3 bits wide with the encoding 000 equal, 001 not-equal, 010 none, 011 jump, 100 signed-less, 101 signed-greater-or-equal, 110 unsigned-less, 111 unsigned-greater-or-equal. Every one of the eight codes is decoded.
- R2: Kind 010 (none) never asserts taken, whatever the operands.
- R3: Kind 011 (jump) always asserts taken, whatever the operands.
- R4: Kind 000 asserts taken exactly when all 32 bits of the two operands match.
- R5: Kind 001 asserts taken exactly when at least one bit of the two operands differs.
- R6: Kind 100 asserts taken exactly when operand A is less than operand B as two's-complement signed values.
- R7: Kind 101 asserts taken exactly when operand A is greater than or equal to operand B as signed values, so equal operands are taken.
- R8: Kind 110 asserts taken exactly when operand A is less than operand B as unsigned values.
- R9: Kind 111 asserts taken exactly when operand A is greater than or equal to operand B as unsigned values.
- R10: The output is purely combinational. It reflects the current inputs with no clock and no latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| br_kind_i | input | 3 | Branch kind from the decoder |
| op_a_i | input | 32 | First register operand |
| op_b_i | input | 32 | Second register operand |
| taken_o | output | 1 | High when the PC must be redirected |

## Verification
The bench targets operand pairs on which the signed and unsigned orderings disagree, for example 0x80000000 against 0x7FFFFFFF and all-ones against zero. A design that mixed up signedness would swap the result for one pair of kinds on exactly these pairs. Equal operands are applied to every kind, which catches a greater-or-equal that was built as strictly greater. Operands that differ only in bit 31 or only in bit 0 expose an equality check that ignores part of the word. The none and jump codes are driven with a range of operand values to show that neither depends on the comparison.

// File: rtl/branch_pkg.sv
package branch_pkg;

    localparam int OPER_W = 32;

    // Bit 0 of each code inverts the base condition of its pair.
    typedef enum logic [2:0] {
        BK_EQ   = 3'b000,
        BK_NE   = 3'b001,
        BK_NONE = 3'b010,
        BK_JUMP = 3'b011,
        BK_LT   = 3'b100,
        BK_GE   = 3'b101,
        BK_LTU  = 3'b110,
        BK_GEU  = 3'b111
    } br_kind_e;

    typedef struct packed {
        logic eq;
        logic lt_s;
        logic lt_u;
    } cmp_flags_t;

    // Base condition of the pair selected by the two upper kind bits.
    function automatic logic pair_base(input logic [1:0] grp, input cmp_flags_t f);
        logic r;
        case (grp)
            2'b00:   r = f.eq;
            2'b01:   r = 1'b0;
            2'b10:   r = f.lt_s;
            default: r = f.lt_u;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/branch_cmp.sv
module branch_cmp
    import branch_pkg::*;
#(
    parameter int W         = OPER_W,
    parameter int CMP_STYLE = 0  // 0: shared subtractor, 1: separate relational compares
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    output cmp_flags_t   flags_o
);
    localparam int MSB = W - 1;

    logic eq_w;
    logic lt_u_w;
    logic lt_s_w;

    assign eq_w = ~|(a_i ^ b_i);

    generate
        if (CMP_STYLE == 0) begin : g_sub
            logic [W:0] diff;
            assign diff   = {1'b0, a_i} - {1'b0, b_i};
            assign lt_u_w = diff[W];
            // Differing signs decide directly; equal signs reuse the unsigned result.
            assign lt_s_w = (a_i[MSB] ^ b_i[MSB]) ? a_i[MSB] : lt_u_w;
        end else begin : g_rel
            assign lt_u_w = (a_i < b_i);
            assign lt_s_w = ($signed(a_i) < $signed(b_i));
        end
    endgenerate

    always_comb begin
        flags_o.eq   = eq_w;
        flags_o.lt_s = lt_s_w;
        flags_o.lt_u = lt_u_w;
    end

endmodule

// File: rtl/branch_sel.sv
module branch_sel
    import branch_pkg::*;
(
    input  br_kind_e   kind_i,
    input  cmp_flags_t flags_i,
    output logic       taken_o
);
    logic [1:0] grp;
    logic       invert;
    logic       base;

    always_comb begin
        grp     = kind_i[2:1];
        invert  = kind_i[0];
        base    = pair_base(grp, flags_i);
        taken_o = base ^ invert;
    end

endmodule

// File: rtl/branch_decide.sv
module branch_decide
    import branch_pkg::*;
#(
    parameter int W         = OPER_W,
    parameter int CMP_STYLE = 0
) (
    input  logic [2:0]   br_kind_i,
    input  logic [W-1:0] op_a_i,
    input  logic [W-1:0] op_b_i,
    output logic         taken_o
);
    cmp_flags_t flags;
    br_kind_e   kind;

    assign kind = br_kind_e'(br_kind_i);

    branch_cmp #(
        .W         (W),
        .CMP_STYLE (CMP_STYLE)
    ) u_cmp (
        .a_i     (op_a_i),
        .b_i     (op_b_i),
        .flags_o (flags)
    );

    branch_sel u_sel (
        .kind_i  (kind),
        .flags_i (flags),
        .taken_o (taken_o)
    );

endmodule

// File: rtl/branch_decide_chk.sv
module branch_decide_chk #(
    parameter int W = 32
) (
    input logic [2:0]   br_kind_i,
    input logic [W-1:0] op_a_i,
    input logic [W-1:0] op_b_i,
    input logic         taken_o
);
    always_comb begin
        if (br_kind_i == 3'b010)
            AST_NONE_NEVER: assert (taken_o == 1'b0);  // R2
        if (br_kind_i == 3'b011)
            AST_JUMP_ALWAYS: assert (taken_o == 1'b1);  // R3
        if (br_kind_i == 3'b101 && op_a_i == op_b_i)
            AST_GE_ON_EQUAL: assert (taken_o == 1'b1);  // R7
        if (br_kind_i == 3'b100 && op_a_i == op_b_i)
            AST_LT_NOT_EQUAL: assert (taken_o == 1'b0);  // R6
        if (br_kind_i == 3'b110 && taken_o == 1'b1)
            AST_LTU_OPS_DIFFER: assert (op_a_i != op_b_i);  // R8
        if (br_kind_i == 3'b111 && op_b_i == '0)
            AST_GEU_VS_ZERO: assert (taken_o == 1'b1);  // R9
        if (br_kind_i == 3'b000 && op_a_i[0] != op_b_i[0])
            AST_EQ_LSB_MISMATCH: assert (taken_o == 1'b0);  // R4
    end
endmodule

bind branch_decide branch_decide_chk #(.W(W)) u_chk (
    .br_kind_i (br_kind_i),
    .op_a_i    (op_a_i),
    .op_b_i    (op_b_i),
    .taken_o   (taken_o)
);

// File: tb/branch_decide_tb.sv
module branch_decide_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [2:0]  kind;
    logic [31:0] opa;
    logic [31:0] opb;
    logic        taken;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    typedef struct {
        logic [2:0]  k;
        logic [31:0] a;
        logic [31:0] b;
        logic        exp;
        string       tag;
    } item_t;

    item_t sb_q[$];

    always #2 clk = ~clk;

    branch_decide u_dut (
        .br_kind_i (kind),
        .op_a_i    (opa),
        .op_b_i    (opb),
        .taken_o   (taken)
    );

    function automatic logic model(input logic [2:0] k, input logic [31:0] a, input logic [31:0] b);
        case (k)
            3'b000:  return a == b;
            3'b001:  return a != b;
            3'b010:  return 1'b0;
            3'b011:  return 1'b1;
            3'b100:  return $signed(a) < $signed(b);
            3'b101:  return $signed(a) >= $signed(b);
            3'b110:  return a < b;
            default: return a >= b;
        endcase
    endfunction

    task automatic drive(input logic [2:0] k, input logic [31:0] a, input logic [31:0] b, input string tag);
        item_t it;
        @(posedge clk);
        #1;
        kind = k;
        opa  = a;
        opb  = b;
        it.k = k; it.a = a; it.b = b; it.exp = model(k, a, b); it.tag = tag;
        sb_q.push_back(it);
    endtask

    // Monitor: compares at the falling edge, away from the driving instant.
    initial begin
        forever begin
            @(negedge clk);
            if (!rst && sb_q.size() > 0) begin
                item_t it;
                it = sb_q.pop_front();
                checks++;
                if (taken !== it.exp) begin
                    errors++;
                    $display("FAIL %s kind=%b a=%h b=%h actual=%b expected=%b",
                             it.tag, it.k, it.a, it.b, taken, it.exp);
                end
            end
        end
    end

    task automatic all_kinds(input logic [31:0] a, input logic [31:0] b);
        for (int k = 0; k < 8; k++) drive(3'(k), a, b, "R1");
    endtask

    initial begin
        kind = 3'b010; opa = '0; opb = '0;
        repeat (3) @(posedge clk);
        rst = 1'b0;
        // Idle state: no-branch code with zero operands is not taken (R2, R10)
        drive(3'b010, 32'h0, 32'h0, "R2");
        drive(3'b010, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R2");
        drive(3'b010, 32'h1234_5678, 32'h0000_0001, "R2");
        drive(3'b011, 32'h0, 32'hFFFF_FFFF, "R3");
        drive(3'b011, 32'h8000_0000, 32'h8000_0000, "R3");
        drive(3'b011, 32'h7FFF_FFFF, 32'h8000_0000, "R3");
        drive(3'b000, 32'hDEAD_BEEF, 32'hDEAD_BEEF, "R4");
        drive(3'b000, 32'h8000_0000, 32'h0000_0000, "R4");
        drive(3'b000, 32'h0000_0001, 32'h0000_0000, "R4");
        drive(3'b001, 32'h8000_0000, 32'h0000_0000, "R5");
        drive(3'b001, 32'h0000_0001, 32'h0000_0000, "R5");
        drive(3'b001, 32'hCAFE_F00D, 32'hCAFE_F00D, "R5");
        drive(3'b100, 32'h8000_0000, 32'h7FFF_FFFF, "R6");
        drive(3'b100, 32'hFFFF_FFFF, 32'h0000_0000, "R6");
        drive(3'b100, 32'h0000_0005, 32'h0000_0005, "R6");
        drive(3'b101, 32'h0000_0005, 32'h0000_0005, "R7");
        drive(3'b101, 32'h7FFF_FFFF, 32'h8000_0000, "R7");
        drive(3'b101, 32'hFFFF_FFFE, 32'hFFFF_FFFF, "R7");
        drive(3'b110, 32'h8000_0000, 32'h7FFF_FFFF, "R8");
        drive(3'b110, 32'h0000_0000, 32'hFFFF_FFFF, "R8");
        drive(3'b110, 32'h0000_0009, 32'h0000_0009, "R8");
        drive(3'b111, 32'h0000_0009, 32'h0000_0009, "R9");
        drive(3'b111, 32'hFFFF_FFFF, 32'h0000_0000, "R9");
        drive(3'b111, 32'h7FFF_FFFF, 32'h8000_0000, "R9");
        // Every code on signedness-disagreeing and equal pairs (R1)
        all_kinds(32'h8000_0000, 32'h7FFF_FFFF);
        all_kinds(32'hFFFF_FFFF, 32'h0000_0000);
        all_kinds(32'h0000_0000, 32'h0000_0000);
        // Pseudo-random mix, fresh inputs each cycle with no latency (R10)
        for (int i = 0; i < 400; i++) begin
            logic [31:0] a, b;
            a = $urandom;
            b = (i % 4 == 0) ? a : $urandom;
            if (i % 7 == 0) b = a ^ 32'h8000_0000;
            drive(3'($urandom), a, b, "R10");
        end
        @(posedge clk);
        @(posedge clk);
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        #(4 * 100000);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule